// File: doc/BRIEF.md
# Flash Buffer DMA Engine

This engine copies a contiguous buffer between system memory and a serial flash byte shifter, so the processor does not have to move each word itself. Software first sets the interrupt enable in the configuration register, then programs a 32-bit memory start address and a length word. The length word holds the plain byte count and a two-bit lane-width code. The transfer begins when software writes the trigger register, and the value written picks the direction. Trigger value 0 moves bytes from the flash into memory. Trigger value 1 moves bytes from memory out to the flash.

The engine works on 32-bit memory words over a simple request/grant port. It breaks each word into bytes, least significant byte first, for the shifter's transmit handshake. It also builds words from bytes taken off the shifter's receive handshake. The last word of a transfer may be partial, and a byte-enable mask then marks the bytes that are valid. When the transfer completes, a pending bit is set. The interrupt line is raised only while that pending bit and the enable bit are both set. The chip select to the flash stays under software control and the engine never drives it.

Top module: `flash_dma`

## Requirements
- R1: Register offsets: configuration 0x00 (bit 20 = interrupt enable, other bits read 0), trigger 0x18 (reads 0), start address 0x1C (all 32 bits read back), pending 0x20 (bit 0), length 0x24 (count in bits 11:0, lane code in bits 29:28, all other bits read 0), status 0x40 (bit 0 = busy).
- R2: Trigger value 0 collects bytes from the receive handshake. Byte i goes to bits 8*(i%4)+7:8*(i%4) of the word at the start address plus 4*(i/4). The low two bits of the start address are taken as zero.
- R3: Trigger value 1 reads words from the start address upward and sends their bytes on the transmit handshake, bits 7:0 first. Exactly the programmed number of bytes is sent.
- R4: Full words carry byte enable 4'hF. A final word of n<4 bytes carries the low n enable bits, and memory bytes outside the mask stay unchanged.
- R5: A read longer than 2080 bytes, or a write longer than 520 bytes, is rejected: no busy, no bus or shifter traffic, no pending. A transfer of exactly the limit runs.
- R6: A zero byte count completes at once. It sets pending and causes no traffic.
- R7: Pending bit 0 sets when a transfer completes. Writing 1 to it clears it and writing 0 has no effect.
- R8: The interrupt output equals interrupt enable AND pending.
- R9: Status busy reads 1 from the cycle after an accepted trigger until the last byte or word handshake, and 0 otherwise.
- R10: A trigger write while busy is ignored, and so is any trigger value other than 0 or 1.
- R11: The lane output carries the lane code from the length word.
- R12: A memory request keeps its address, direction and data stable until it is granted. Read data is taken in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_gnt | input | 1 | Memory grant |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| fl_lanes | output | 2 | Lane-width code to the shifter |
| fl_tx_valid | output | 1 | Transmit byte valid |
| fl_tx_byte | output | 8 | Transmit byte |
| fl_tx_ready | input | 1 | Shifter accepts transmit byte |
| fl_rx_valid | input | 1 | Receive byte valid |
| fl_rx_byte | input | 8 | Receive byte |
| fl_rx_ready | output | 1 | Engine accepts receive byte |

## Verification
The bench builds the engine with its default parameters: a 12-bit count field and limits of 2080 bytes for reads and 520 for writes. This lets the same build run transfers of exactly the limit and of one byte past it, in both directions. Grant, ready and valid are given out at random, so every byte position of a partial last word is reached at the mask boundary. Unaligned start addresses, and trigger writes made while a transfer runs, are mixed in with random lengths.

// File: rtl/flash_dma_pkg.sv
package flash_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_SEND,
    S_GATHER,
    S_STORE
  } seq_state_e;

  localparam logic [7:0] OFS_CFG  = 8'h00;
  localparam logic [7:0] OFS_TRIG = 8'h18;
  localparam logic [7:0] OFS_ADDR = 8'h1C;
  localparam logic [7:0] OFS_PEND = 8'h20;
  localparam logic [7:0] OFS_LEN  = 8'h24;
  localparam logic [7:0] OFS_STAT = 8'h40;

  localparam int IE_BIT   = 20;
  localparam int LANE_LSB = 28;

  // bytes handled in the current word: four, or what is left
  function automatic logic [2:0] chunk_of(input logic [31:0] rem);
    if (rem >= 32'd4) return 3'd4;
    return rem[2:0];
  endfunction

  // contiguous low byte-enable mask for n bytes
  function automatic logic [3:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/flash_dma_regs.sv
module flash_dma_regs
  import flash_dma_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [7:0]       reg_raddr,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             done_evt,
  output logic             trig_wr,
  output logic [31:0]      trig_val,
  output logic [31:0]      start_addr,
  output logic [LEN_W-1:0] len_count,
  output logic [1:0]       lanes,
  output logic             irq
);

  logic ie_q;
  logic pend_q;
  logic pend_clr;

  assign trig_wr  = reg_wr && (reg_addr == OFS_TRIG);
  assign trig_val = reg_wdata;
  assign pend_clr = reg_wr && (reg_addr == OFS_PEND) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q       <= 1'b0;
      pend_q     <= 1'b0;
      start_addr <= '0;
      len_count  <= '0;
      lanes      <= 2'b00;
    end else begin
      if (reg_wr && reg_addr == OFS_CFG)  ie_q <= reg_wdata[IE_BIT];
      if (reg_wr && reg_addr == OFS_ADDR) start_addr <= reg_wdata;
      if (reg_wr && reg_addr == OFS_LEN) begin
        len_count <= reg_wdata[LEN_W-1:0];
        lanes     <= reg_wdata[LANE_LSB+1:LANE_LSB];
      end
      // a completion in the clearing cycle wins
      pend_q <= (pend_q && !pend_clr) || done_evt;
    end
  end

  assign irq = ie_q && pend_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      OFS_CFG:  reg_rdata[IE_BIT] = ie_q;
      OFS_ADDR: reg_rdata = start_addr;
      OFS_PEND: reg_rdata[0] = pend_q;
      OFS_LEN: begin
        reg_rdata[LEN_W-1:0]             = len_count;
        reg_rdata[LANE_LSB+1:LANE_LSB]   = lanes;
      end
      OFS_STAT: reg_rdata[0] = busy;
      default:  reg_rdata = '0;
    endcase
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> pend_q) else $error("pending not set"); // R7
  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr && !done_evt |=> !pend_q) else $error("pending not cleared"); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> !irq) else $error("irq without pending"); // R8

endmodule

// File: rtl/flash_dma_lanes.sv
module flash_dma_lanes
  import flash_dma_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  idx,
  input  logic [7:0]  rx_byte,
  input  logic [2:0]  n,
  output logic [7:0]  tx_byte,
  output logic [31:0] word_ins,
  output logic [3:0]  be
);

  assign tx_byte = word[{idx, 3'b000} +: 8];
  assign be      = lane_mask(n);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign word_ins[8*k +: 8] = (idx == 2'(k)) ? rx_byte : word[8*k +: 8];
  end

endmodule

// File: rtl/flash_dma_seq.sv
module flash_dma_seq
  import flash_dma_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int RD_MAX = 2080,
  parameter int WR_MAX = 520
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_wr,
  input  logic [31:0]      trig_val,
  input  logic [31:0]      start_addr,
  input  logic [LEN_W-1:0] len_count,
  output logic             busy,
  output logic             done_evt,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  output logic             fl_tx_valid,
  output logic [7:0]       fl_tx_byte,
  input  logic             fl_tx_ready,
  input  logic             fl_rx_valid,
  input  logic [7:0]       fl_rx_byte,
  output logic             fl_rx_ready
);

  seq_state_e       state;
  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] remain;
  logic [31:0]      word;
  logic [1:0]       idx;

  logic [2:0]  n;
  logic [31:0] word_ins;
  logic        dir_rd, dir_wr, limit_ok, start_ok;
  logic        last_byte, final_chunk, chunk_done;
  logic        tx_fire, rx_fire, store_fire;

  assign dir_rd   = (trig_val == 32'd0);
  assign dir_wr   = (trig_val == 32'd1);
  assign limit_ok = dir_rd ? (32'(len_count) <= 32'(RD_MAX))
                           : (32'(len_count) <= 32'(WR_MAX));
  assign start_ok = trig_wr && (state == S_IDLE) && (dir_rd || dir_wr) && limit_ok;

  assign n           = chunk_of(32'(remain));
  assign last_byte   = ({1'b0, idx} == (n - 3'd1));
  assign final_chunk = (32'(remain) == 32'(n));
  assign tx_fire     = (state == S_SEND) && fl_tx_ready;
  assign rx_fire     = (state == S_GATHER) && fl_rx_valid;
  assign store_fire  = (state == S_STORE) && mem_gnt;
  assign chunk_done  = (tx_fire && last_byte) || store_fire;
  assign done_evt    = (start_ok && len_count == '0) || (chunk_done && final_chunk);

  flash_dma_lanes u_lanes (
    .word    (word),
    .idx     (idx),
    .rx_byte (fl_rx_byte),
    .n       (n),
    .tx_byte (fl_tx_byte),
    .word_ins(word_ins),
    .be      (mem_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      word     <= '0;
      idx      <= 2'd0;
    end else begin
      case (state)
        S_IDLE: if (start_ok) begin
          cur_addr <= {start_addr[31:2], 2'b00};
          remain   <= len_count;
          word     <= '0;
          idx      <= 2'd0;
          if (len_count == '0) state <= S_IDLE;
          else                 state <= dir_wr ? S_FETCH : S_GATHER;
        end
        S_FETCH: if (mem_gnt) begin
          word  <= mem_rdata;
          idx   <= 2'd0;
          state <= S_SEND;
        end
        S_SEND: if (fl_tx_ready) begin
          if (last_byte) begin
            cur_addr <= cur_addr + 32'd4;
            remain   <= remain - LEN_W'(n);
            idx      <= 2'd0;
            state    <= final_chunk ? S_IDLE : S_FETCH;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_GATHER: if (rx_fire) begin
          word <= word_ins;
          if (last_byte) state <= S_STORE;
          else           idx   <= idx + 2'd1;
        end
        S_STORE: if (mem_gnt) begin
          cur_addr <= cur_addr + 32'd4;
          remain   <= remain - LEN_W'(n);
          idx      <= 2'd0;
          word     <= '0;
          state    <= final_chunk ? S_IDLE : S_GATHER;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign mem_req     = (state == S_FETCH) || (state == S_STORE);
  assign mem_we      = (state == S_STORE);
  assign mem_addr    = cur_addr;
  assign mem_wdata   = word;
  assign fl_tx_valid = (state == S_SEND);
  assign fl_rx_ready = (state == S_GATHER);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
    else $error("request changed before grant"); // R12
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF))
    else $error("byte enable not contiguous"); // R4
  AST_REMAIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(remain) <= 32'(RD_MAX)))
    else $error("count above limit"); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_tx_valid && !fl_tx_ready |=> fl_tx_valid && $stable(fl_tx_byte))
    else $error("tx byte dropped"); // R3
  AST_BUSY_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_wr))
    else $error("busy without trigger"); // R9
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trig_wr && !chunk_done |=> $stable(remain))
    else $error("trigger while busy reloaded"); // R10

endmodule

// File: rtl/flash_dma.sv
module flash_dma
  import flash_dma_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int RD_MAX = 2080,
  parameter int WR_MAX = 520
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [7:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic [1:0]  fl_lanes,
  output logic        fl_tx_valid,
  output logic [7:0]  fl_tx_byte,
  input  logic        fl_tx_ready,
  input  logic        fl_rx_valid,
  input  logic [7:0]  fl_rx_byte,
  output logic        fl_rx_ready
);

  logic             busy, done_evt, trig_wr;
  logic [31:0]      trig_val, start_addr;
  logic [LEN_W-1:0] len_count;

  flash_dma_regs #(.LEN_W(LEN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .done_evt  (done_evt),
    .trig_wr   (trig_wr),
    .trig_val  (trig_val),
    .start_addr(start_addr),
    .len_count (len_count),
    .lanes     (fl_lanes),
    .irq       (irq)
  );

  flash_dma_seq #(.LEN_W(LEN_W), .RD_MAX(RD_MAX), .WR_MAX(WR_MAX)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_wr    (trig_wr),
    .trig_val   (trig_val),
    .start_addr (start_addr),
    .len_count  (len_count),
    .busy       (busy),
    .done_evt   (done_evt),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_be     (mem_be),
    .mem_gnt    (mem_gnt),
    .mem_rdata  (mem_rdata),
    .fl_tx_valid(fl_tx_valid),
    .fl_tx_byte (fl_tx_byte),
    .fl_tx_ready(fl_tx_ready),
    .fl_rx_valid(fl_rx_valid),
    .fl_rx_byte (fl_rx_byte),
    .fl_rx_ready(fl_rx_ready)
  );

endmodule

// File: tb/test_flash_dma.sv
`timescale 1ns/1ps
module test_flash_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  fl_lanes;
  logic        fl_tx_valid;
  logic [7:0]  fl_tx_byte;
  logic        fl_tx_ready = 1'b0;
  logic        fl_rx_valid = 1'b0;
  logic [7:0]  fl_rx_byte = '0;
  logic        fl_rx_ready;

  always #4 clk = ~clk;

  flash_dma i_flash_dma (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem  [0:1023];
  logic [31:0] expm [0:1023];
  logic [7:0]  src  [0:4095];
  logic [7:0]  cap  [0:4095];
  int cap_n = 0, rx_ptr = 0, hs = 0, hold_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus and shifter responders, all decisions made at the falling edge
  initial begin
    bit          wait_q = 0;
    logic [31:0] pa = '0;
    logic        pw = 0;
    forever begin
      @(negedge clk);
      if (wait_q && (!mem_req || mem_addr != pa || mem_we != pw)) hold_err++;
      mem_gnt = mem_req && ($urandom % 4 != 0);
      if (mem_gnt) begin
        hs++;
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[11:2]][8*k +: 8] = mem_wdata[8*k +: 8];
        end else mem_rdata = mem[mem_addr[11:2]];
      end
      wait_q = mem_req && !mem_gnt;
      pa = mem_addr; pw = mem_we;
      fl_tx_ready = ($urandom % 3 != 0);
      if (fl_tx_valid && fl_tx_ready) begin cap[cap_n % 4096] = fl_tx_byte; cap_n++; hs++; end
      fl_rx_valid = ($urandom % 4 != 0);
      fl_rx_byte  = src[rx_ptr % 4096];
      if (fl_rx_valid && fl_rx_ready) begin rx_ptr++; hs++; end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int t = 0;
    do begin @(negedge clk); rd(8'h40, s); t++; end while (s[0] && t < 20000);
    chk(!s[0], req, "transfer did not finish", s, 0);
  endtask

  function automatic logic [31:0] len_word(input int len, input logic [1:0] ln);
    logic [31:0] w = 32'(len) & 32'hFFF;
    w[29:28] = ln;
    return w;
  endfunction

  task automatic prep();
    for (int i = 0; i < 1024; i++) begin mem[i] = $urandom; expm[i] = mem[i]; end
    for (int i = 0; i < 4096; i++) src[i] = 8'($urandom);
    cap_n = 0; rx_ptr = 0;
  endtask

  task automatic check_data(input bit wr_dir, input int base, input int len);
    int bad = 0;
    int wb = (base >> 2);
    if (!wr_dir) begin
      for (int i = 0; i < len; i++) expm[wb + i/4][8*(i%4) +: 8] = src[i];
      for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) bad++;
      chk(bad == 0, "R2", "memory words wrong", bad, 0);
      chk(bad == 0, "R4", "partial word mask", bad, 0);
      chk(rx_ptr == len, "R2", "bytes taken", rx_ptr, len);
    end else begin
      chk(cap_n == len, "R3", "bytes sent", cap_n, len);
      for (int i = 0; i < len && i < cap_n; i++)
        if (cap[i] !== expm[wb + i/4][8*(i%4) +: 8]) bad++;
      chk(bad == 0, "R3", "sent byte mismatches", bad, 0);
    end
  endtask

  task automatic xfer(input bit wr_dir, input int base, input int len,
                      input logic [1:0] ln, input bit ie);
    logic [31:0] s;
    int lim = wr_dir ? 520 : 2080;
    int hs0;
    prep();
    wr(8'h00, ie ? 32'h0010_0000 : 32'h0);
    wr(8'h1C, 32'(base));
    wr(8'h24, len_word(len, ln));
    hs0 = hs;
    wr(8'h18, wr_dir ? 32'd1 : 32'd0);
    rd(8'h40, s);
    if (len > lim) begin
      repeat (5) @(negedge clk);
      rd(8'h40, s); chk(s[0] == 0, "R5", "busy on oversize", s, 0);
      chk(hs == hs0, "R5", "traffic on oversize", hs - hs0, 0);
      rd(8'h20, s); chk(s[0] == 0, "R5", "pending on oversize", s, 0);
      return;
    end
    if (len == 0) begin
      chk(s[0] == 0, "R6", "busy on zero length", s, 0);
      repeat (3) @(negedge clk);
      chk(hs == hs0, "R6", "traffic on zero length", hs - hs0, 0);
    end else begin
      chk(s[0] == 1, "R9", "busy while running", s, 1);
      wait_idle("R9");
      check_data(wr_dir, base & ~3, len);
    end
    rd(8'h20, s); chk(s[0] == 1, "R7", "pending after done", s, 1);
    chk(irq == ie, "R8", "irq level", irq, ie);
    chk(fl_lanes == ln, "R11", "lane code", fl_lanes, ln);
    wr(8'h20, 32'h0); rd(8'h20, s);
    chk(s[0] == 1, "R7", "write 0 kept pending", s, 1);
    wr(8'h20, 32'h1); rd(8'h20, s);
    chk(s[0] == 0, "R7", "write 1 cleared", s, 0);
    chk(irq == 0, "R8", "irq after clear", irq, 0);
  endtask

  initial begin
    logic [31:0] s;
    int hs0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R9 reset state
    rd(8'h40, s); chk(s == 0, "R9", "reset status", s, 0);
    rd(8'h20, s); chk(s == 0, "R7", "reset pending", s, 0);
    chk(irq == 0 && mem_req == 0, "R1", "reset outputs", {irq, mem_req}, 0);
    // R1 register readback
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, s); chk(s == 32'h0010_0000, "R1", "config readback", s, 32'h0010_0000);
    wr(8'h1C, 32'hDEAD_BEEF); rd(8'h1C, s); chk(s == 32'hDEAD_BEEF, "R1", "address readback", s, 32'hDEAD_BEEF);
    wr(8'h24, 32'hFFFF_F123); rd(8'h24, s); chk(s == 32'h3000_0123, "R1", "length readback", s, 32'h3000_0123);
    rd(8'h18, s); chk(s == 0, "R1", "trigger reads zero", s, 0);
    // directed corners
    xfer(0, 64, 5, 2'd1, 1);
    xfer(1, 130, 7, 2'd2, 1);
    xfer(0, 400, 4, 2'd0, 0);
    xfer(1, 8, 0, 2'd0, 1);
    xfer(0, 0, 2080, 2'd2, 1);
    xfer(0, 0, 2081, 2'd2, 1);
    xfer(1, 4, 520, 2'd1, 1);
    xfer(1, 4, 521, 2'd1, 1);
    // R10 unknown trigger value
    prep(); wr(8'h24, len_word(8, 2'd0)); hs0 = hs;
    wr(8'h18, 32'd2); repeat (4) @(negedge clk);
    rd(8'h40, s); chk(s[0] == 0, "R10", "value 2 started", s, 0);
    chk(hs == hs0, "R10", "value 2 traffic", hs - hs0, 0);
    // R10 trigger while busy
    prep(); wr(8'h1C, 32'd256); wr(8'h24, len_word(64, 2'd0));
    wr(8'h18, 32'd0); repeat (3) @(negedge clk);
    wr(8'h24, len_word(9, 2'd0)); wr(8'h18, 32'd1);
    wait_idle("R10");
    chk(cap_n == 0, "R10", "write started while busy", cap_n, 0);
    check_data(0, 256, 64);
    wr(8'h20, 32'h1);
    // random mix
    for (int r = 0; r < 24; r++) begin
      bit d = 1'($urandom);
      int ln = 1 + int'($urandom % 120);
      int b = int'($urandom % 2000);
      xfer(d, b, ln, 2'($urandom), 1'($urandom));
    end
    chk(hold_err == 0, "R12", "request changed before grant", hold_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule